// File: doc/BRIEF.md
# Prescaled compare timer core

This block is a 24-bit up-counter with an 8-bit prescaler and a 24-bit compare value. In the default mode the counter advances once every PRESC+1 clocks. When it reaches the compare value, a sticky match flag is raised. On the next counting cycle the counter and prescaler return to zero, so the timer runs periodically. In event mode the prescaler is bypassed and the counter instead steps once per selected edge of an external event pin. A four-sample debounce filter can be placed in front of that pin.

Software drives the block through a flat register port: one write strobe with address and data, and one combinational read path. The block raises an interrupt, a wake-up request, and single-cycle trigger pulses meant for an ADC and a DMA controller. Other inputs are a debug-acknowledge that can freeze counting, and a capture-event strobe from a neighbouring capture unit that sets a second sticky flag.

The register addresses are CFG=0, PRESC=1, CMP=2, IEN=3, STAT=4 and CNT=5. CNT is read-only, and addresses 6 and 7 read zero. The CFG bits are:
- bit 0: run
- bit 1: soft reset
- bit 2: wake enable
- bit 3: debug-free
- bit 4: event mode
- bit 5: rising edge (1) or falling edge (0)
- bit 6: filter enable
- bit 7: trigger source (1 = capture flag)
- bit 8: ADC trigger enable
- bit 9: DMA trigger enable
- bit 15: active, read-only

Top module: `pscmp_timer`

## Requirements
- R1: With run set (CFG bit 0) and event mode off, the counter read at CNT is floor(n/(P+1)) after n clocks for n up to C*(P+1), where P=PRESC and C=CMP. It holds C for one clock and then restarts from 0, giving a period of C*(P+1)+1 clocks.
- R2: STAT bit 0 is set on the clock edge at which the counter steps onto C. It stays set until written with 1. Writing 0 to it has no effect. If a match and a clearing write fall on the same edge, the bit stays set.
- R3: irq_o is high exactly when (STAT bit 0 and IEN bit 0) or (STAT bit 1 and IEN bit 1).
- R4: A write to CMP forces the counter and the prescaler to zero on that edge, whether or not run is set. Counting resumes from zero with the new value.
- R5: Writing CFG with bit 1 set clears run, the counter and the prescaler. CFG bit 1 then reads 1 for exactly 3 clocks after the write and clears itself. Counting stays stopped until run is written again.
- R6: While dbg_ack_i is high and CFG bit 3 is 0, the counter holds and CFG bit 15 reads 0. When CFG bit 3 is 1, counting continues regardless of dbg_ack_i. CFG bit 15 reads 1 whenever the counter is allowed to advance.
- R7: With CFG bit 4 set, the counter steps by one for each edge of evt_pin_i of the kind chosen by CFG bit 5 (1 rising, 0 falling). It keeps its value otherwise, and the prescaler has no effect.
- R8: With CFG bit 6 set, a new pin level is accepted only after 4 consecutive equal samples. A pulse shorter than 4 clocks is ignored.
- R9: wake_o is high when CFG bit 2 is set and STAT bit 0 or STAT bit 1 is set. STAT bit 2 is then set, and it is cleared by writing 1 to it.
- R10: Each rising edge of the flag chosen by CFG bit 7 (0 = STAT bit 0, 1 = STAT bit 1) gives a one-clock pulse on adc_trg_o if CFG bit 8 is set, and on dma_trg_o if CFG bit 9 is set. A flag that stays high gives no further pulses.
- R11: A one-clock pulse on cap_evt_i sets STAT bit 1, which is cleared by writing 1 to it.
- R12: After reset, CNT, CFG, PRESC, IEN and STAT read 0, CMP reads all ones, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 24 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 24 | Read data (combinational) |
| evt_pin_i | input | 1 | External event pin, synchronous to clk |
| cap_evt_i | input | 1 | Capture event strobe from a neighbour unit |
| dbg_ack_i | input | 1 | Debug acknowledge |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake-up request |
| adc_trg_o | output | 1 | One-clock ADC trigger |
| dma_trg_o | output | 1 | One-clock DMA trigger |

## Verification
Two functions can meet on the same clock edge: the hardware match that sets STAT bit 0, and a software write of 1 that clears it. The bench provokes this with a prescale of 0 and a compare value of 10. It starts the timer and times a STAT write so that it lands on exactly the tenth counting edge. It then judges the outcome by reading STAT bit 0, which must still be 1, and CNT, which must equal 10. A second clearing write, away from any match, must drop the flag.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_CFG   = 3'd0,
        REG_PRESC = 3'd1,
        REG_CMP   = 3'd2,
        REG_IEN   = 3'd3,
        REG_STAT  = 3'd4,
        REG_CNT   = 3'd5
    } reg_addr_e;

    localparam int CFG_RUN     = 0;
    localparam int CFG_SRST    = 1;
    localparam int CFG_WAKE    = 2;
    localparam int CFG_DBGFREE = 3;
    localparam int CFG_EVT     = 4;
    localparam int CFG_RISE    = 5;
    localparam int CFG_FILT    = 6;
    localparam int CFG_TSEL    = 7;
    localparam int CFG_ADC     = 8;
    localparam int CFG_DMA     = 9;
    localparam int CFG_ACT     = 15;

    localparam int ST_MATCH = 0;
    localparam int ST_CAP   = 1;
    localparam int ST_WAKE  = 2;

    typedef struct packed {
        logic run;
        logic wake_en;
        logic dbg_free;
        logic evt_mode;
        logic evt_rise;
        logic evt_filt;
        logic tsel;
        logic adc_en;
        logic dma_en;
    } cfg_t;

endpackage

// File: rtl/tmr_evt_filter.sv
module tmr_evt_filter #(
    parameter int DEB_N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic filt_en,
    input  logic rise_sel,
    output logic step
);

    typedef struct packed {
        logic [DEB_N-1:0] sh;
        logic             lvl;
        logic             prev;
    } flt_t;

    flt_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sh   = {s_q.sh[DEB_N-2:0], pin};
        s_d.prev = s_q.lvl;
        if (!filt_en) begin
            s_d.lvl = pin;
        end else if (&s_d.sh) begin
            s_d.lvl = 1'b1;
        end else if (~|s_d.sh) begin
            s_d.lvl = 1'b0;
        end
        step = rise_sel ? (s_q.lvl & ~s_q.prev) : (~s_q.lvl & s_q.prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R7
    step_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (!step || $changed(rise_sel)));

    // R8
    filt_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_en && $past(filt_en) && $rose(s_q.lvl)) |-> $past(pin));

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
    parameter int CNT_W = 24,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic             evt_mode,
    input  logic             evt_step,
    input  logic [PRE_W-1:0] presc,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] cnt,
    output logic             match
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [PRE_W-1:0] PRE_ONE = PRE_W'(1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
    } core_t;

    core_t s_d, s_q;
    logic  step;
    logic  pre_full;

    always_comb begin
        s_d      = s_q;
        step     = 1'b0;
        match    = 1'b0;
        pre_full = (s_q.pre == presc);
        if (restart) begin
            s_d.pre = '0;
            s_d.cnt = '0;
        end else if (en) begin
            if (s_q.cnt == cmp) begin
                s_d.pre = '0;
                s_d.cnt = '0;
            end else begin
                if (evt_mode) begin
                    s_d.pre = '0;
                    step    = evt_step;
                end else begin
                    s_d.pre = pre_full ? '0 : s_q.pre + PRE_ONE;
                    step    = pre_full;
                end
                if (step) begin
                    s_d.cnt = s_q.cnt + CNT_ONE;
                    match   = ((s_q.cnt + CNT_ONE) == cmp);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt = s_q.cnt;

    // R4
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (s_q.cnt == '0 && s_q.pre == '0));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !restart) |=> $stable(s_q.cnt));

    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && $past(!restart) && $stable(cmp)) |-> (s_q.cnt <= cmp));

endmodule

// File: rtl/pscmp_timer.sv
module pscmp_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W    = 24,
    parameter int PRE_W    = 8,
    parameter int DEB_N    = 4,
    parameter int SRST_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    input  logic              evt_pin_i,
    input  logic              cap_evt_i,
    input  logic              dbg_ack_i,
    output logic              irq_o,
    output logic              wake_o,
    output logic              adc_trg_o,
    output logic              dma_trg_o
);

    localparam int SRST_W = $clog2(SRST_CYC + 1);
    localparam logic [SRST_W-1:0] SRST_ONE = SRST_W'(1);

    typedef struct packed {
        cfg_t             cfg;
        logic [PRE_W-1:0] presc;
        logic [CNT_W-1:0] cmp;
        logic [1:0]       ien;
        logic             st_match;
        logic             st_cap;
        logic             st_wake;
        logic [SRST_W-1:0] srst;
        logic             trg_prev;
    } regs_t;

    regs_t r_d, r_q;

    logic [CNT_W-1:0] cnt_w;
    logic match_w, evt_step_w;
    logic busy, halt, cnt_en, restart, srst_req, trg_sel, trg_rise;
    logic wr_cfg, wr_presc, wr_cmp, wr_ien, wr_stat;
    logic [2:0] clr;

    tmr_evt_filter #(.DEB_N(DEB_N)) u_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (evt_pin_i),
        .filt_en  (r_q.cfg.evt_filt),
        .rise_sel (r_q.cfg.evt_rise),
        .step     (evt_step_w)
    );

    tmr_count_core #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cnt_en),
        .restart  (restart),
        .evt_mode (r_q.cfg.evt_mode),
        .evt_step (evt_step_w),
        .presc    (r_q.presc),
        .cmp      (r_q.cmp),
        .cnt      (cnt_w),
        .match    (match_w)
    );

    always_comb begin
        wr_cfg   = wr_en && (wr_addr == REG_CFG);
        wr_presc = wr_en && (wr_addr == REG_PRESC);
        wr_cmp   = wr_en && (wr_addr == REG_CMP);
        wr_ien   = wr_en && (wr_addr == REG_IEN);
        wr_stat  = wr_en && (wr_addr == REG_STAT);
        busy     = (r_q.srst != '0);
        halt     = dbg_ack_i & ~r_q.cfg.dbg_free;
        cnt_en   = r_q.cfg.run & ~halt & ~busy;
        srst_req = wr_cfg & wr_data[CFG_SRST];
        restart  = wr_cmp | busy | srst_req;
        clr      = wr_stat ? wr_data[2:0] : 3'b000;
        trg_sel  = r_q.cfg.tsel ? r_q.st_cap : r_q.st_match;
        trg_rise = trg_sel & ~r_q.trg_prev;

        r_d = r_q;
        if (busy) begin
            r_d.srst    = r_q.srst - SRST_ONE;
            r_d.cfg.run = 1'b0;
        end
        if (wr_cfg) begin
            r_d.cfg.run      = wr_data[CFG_RUN] & ~wr_data[CFG_SRST] & ~busy;
            r_d.cfg.wake_en  = wr_data[CFG_WAKE];
            r_d.cfg.dbg_free = wr_data[CFG_DBGFREE];
            r_d.cfg.evt_mode = wr_data[CFG_EVT];
            r_d.cfg.evt_rise = wr_data[CFG_RISE];
            r_d.cfg.evt_filt = wr_data[CFG_FILT];
            r_d.cfg.tsel     = wr_data[CFG_TSEL];
            r_d.cfg.adc_en   = wr_data[CFG_ADC];
            r_d.cfg.dma_en   = wr_data[CFG_DMA];
            if (srst_req) r_d.srst = SRST_W'(SRST_CYC);
        end
        if (wr_presc) r_d.presc = wr_data[PRE_W-1:0];
        if (wr_cmp)   r_d.cmp   = wr_data;
        if (wr_ien)   r_d.ien   = wr_data[1:0];

        r_d.st_match = (r_q.st_match & ~clr[ST_MATCH]) | match_w;
        r_d.st_cap   = (r_q.st_cap & ~clr[ST_CAP]) | cap_evt_i;
        r_d.st_wake  = (r_q.st_wake & ~clr[ST_WAKE]) | wake_o;
        r_d.trg_prev = trg_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.cmp <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign irq_o     = (r_q.st_match & r_q.ien[0]) | (r_q.st_cap & r_q.ien[1]);
    assign wake_o    = r_q.cfg.wake_en & (r_q.st_match | r_q.st_cap);
    assign adc_trg_o = trg_rise & r_q.cfg.adc_en;
    assign dma_trg_o = trg_rise & r_q.cfg.dma_en;

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            REG_CFG: begin
                rd_data[CFG_RUN]     = r_q.cfg.run;
                rd_data[CFG_SRST]    = busy;
                rd_data[CFG_WAKE]    = r_q.cfg.wake_en;
                rd_data[CFG_DBGFREE] = r_q.cfg.dbg_free;
                rd_data[CFG_EVT]     = r_q.cfg.evt_mode;
                rd_data[CFG_RISE]    = r_q.cfg.evt_rise;
                rd_data[CFG_FILT]    = r_q.cfg.evt_filt;
                rd_data[CFG_TSEL]    = r_q.cfg.tsel;
                rd_data[CFG_ADC]     = r_q.cfg.adc_en;
                rd_data[CFG_DMA]     = r_q.cfg.dma_en;
                rd_data[CFG_ACT]     = cnt_en;
            end
            REG_PRESC: rd_data[PRE_W-1:0] = r_q.presc;
            REG_CMP:   rd_data = r_q.cmp;
            REG_IEN:   rd_data[1:0] = r_q.ien;
            REG_STAT:  rd_data[2:0] = {r_q.st_wake, r_q.st_cap, r_q.st_match};
            REG_CNT:   rd_data = cnt_w;
            default:   rd_data = '0;
        endcase
    end

    // R10
    trg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_trg_o || dma_trg_o) |=> !(adc_trg_o || dma_trg_o) || $changed(r_q.cfg.tsel));

    // R5
    srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst_req |=> (!r_q.cfg.run && cnt_w == '0));

    // R9
    wake_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> r_q.st_wake);

    // R2
    match_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_w |=> r_q.st_match);

endmodule

// File: tb/pscmp_timer_tb.sv
module pscmp_timer_tb_top;
    import tmr_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [23:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [23:0] rd_data;
    logic evt_pin_i = 1'b0, cap_evt_i = 1'b0, dbg_ack_i = 1'b0;
    logic irq_o, wake_o, adc_trg_o, dma_trg_o;

    int n_cmp = 0;
    int n_bad = 0;
    int adc_seen = 0;
    int dma_seen = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pscmp_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .evt_pin_i(evt_pin_i), .cap_evt_i(cap_evt_i),
        .dbg_ack_i(dbg_ack_i), .irq_o(irq_o), .wake_o(wake_o),
        .adc_trg_o(adc_trg_o), .dma_trg_o(dma_trg_o)
    );

    always @(negedge clk) begin
        if (adc_trg_o) adc_seen++;
        if (dma_trg_o) dma_seen++;
    end

    function automatic int exp_cnt(int n, int p, int c);
        int per;
        per = c * (p + 1) + 1;
        return (n % per) / (p + 1);
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [23:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int v, p, c, k, ie, base_a, base_d;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        rd(REG_CNT, v);  chk("R12 cnt", v, 0);
        rd(REG_CFG, v);  chk("R12 cfg", v, 0);
        rd(REG_STAT, v); chk("R12 stat", v, 0);
        rd(REG_CMP, v);  chk("R12 cmp", v, 24'hFFFFFF);
        chk("R12 outs", {irq_o, wake_o, adc_trg_o, dma_trg_o}, 0);

        // R1 R2 R3 random prescale/compare runs
        for (int it = 0; it < 12; it++) begin
            p = $urandom % 4; c = 2 + $urandom % 6; k = $urandom % 70; ie = $urandom % 2;
            wr(REG_PRESC, 24'(p));
            wr(REG_CMP, 24'(c));
            wr(REG_STAT, 24'h7);
            wr(REG_IEN, 24'(ie));
            wr(REG_CFG, 24'h1);
            wait_n(k);
            rd(REG_CNT, v);  chk("R1 count", v, exp_cnt(k, p, c));
            rd(REG_STAT, v); chk("R2 match flag", v & 1, (k >= c * (p + 1)) ? 1 : 0);
            chk("R3 irq", int'(irq_o), (ie == 1 && k >= c * (p + 1)) ? 1 : 0);
            wr(REG_CFG, 24'h0);
        end

        // R2 write 0 ignored, write 1 clears
        wr(REG_PRESC, 24'h0); wr(REG_CMP, 24'd3); wr(REG_CFG, 24'h1);
        wait_n(6); wr(REG_CFG, 24'h0);
        wr(REG_STAT, 24'h0); rd(REG_STAT, v); chk("R2 write0 kept", v & 1, 1);
        wr(REG_STAT, 24'h1); rd(REG_STAT, v); chk("R2 w1c", v & 1, 0);

        // R2 collision: match and clear on the same edge
        wr(REG_CMP, 24'd10); wr(REG_STAT, 24'h7); wr(REG_CFG, 24'h1);
        wait_n(9);
        wr(REG_STAT, 24'h1);
        rd(REG_STAT, v); chk("R2 set wins", v & 1, 1);
        rd(REG_CNT, v);  chk("R1 holds cmp", v, 10);
        wr(REG_CFG, 24'h0);
        wr(REG_STAT, 24'h1); rd(REG_STAT, v); chk("R2 later clear", v & 1, 0);

        // R4 compare write restarts
        wr(REG_CMP, 24'd200); wr(REG_CFG, 24'h1);
        wait_n(20); rd(REG_CNT, v); chk("R4 pre", v, 20);
        wr(REG_CMP, 24'd100); rd(REG_CNT, v); chk("R4 restart", v, 0);
        wait_n(5); rd(REG_CNT, v); chk("R4 resume", v, 5);
        wr(REG_CFG, 24'h0);
        wr(REG_CMP, 24'd50); rd(REG_CNT, v); chk("R4 stopped restart", v, 0);

        // R5 soft reset
        wr(REG_CMP, 24'd100); wr(REG_CFG, 24'h1); wait_n(7);
        wr(REG_CFG, 24'h3);
        rd(REG_CFG, v); chk("R5 busy", (v >> 1) & 1, 1);
        chk("R5 run cleared", v & 1, 0);
        rd(REG_CNT, v); chk("R5 cnt cleared", v, 0);
        wait_n(2); rd(REG_CFG, v); chk("R5 busy 3rd", (v >> 1) & 1, 1);
        wait_n(1); rd(REG_CFG, v); chk("R5 autoclear", (v >> 1) & 1, 0);
        wait_n(5); rd(REG_CNT, v); chk("R5 stays", v, 0);

        // R6 debug halt
        wr(REG_CMP, 24'd100); wr(REG_CFG, 24'h1);
        dbg_ack_i = 1'b1;
        wait_n(5); rd(REG_CNT, v); chk("R6 held", v, 0);
        rd(REG_CFG, v); chk("R6 inactive", (v >> 15) & 1, 0);
        wr(REG_CFG, 24'h9);
        wait_n(6); rd(REG_CNT, v); chk("R6 free", v, 6);
        rd(REG_CFG, v); chk("R6 active", (v >> 15) & 1, 1);
        dbg_ack_i = 1'b0;
        wr(REG_CFG, 24'h0);

        // R7 event counting
        wr(REG_CMP, 24'd1000); wr(REG_PRESC, 24'd3);
        wr(REG_CFG, 24'h31);
        evt_pin_i = 1'b1; wait_n(4); rd(REG_CNT, v); chk("R7 rise", v, 1);
        evt_pin_i = 1'b0; wait_n(4); rd(REG_CNT, v); chk("R7 fall ignored", v, 1);
        for (int i = 0; i < 3; i++) begin
            evt_pin_i = 1'b1; wait_n(2); evt_pin_i = 1'b0; wait_n(2);
        end
        wait_n(2); rd(REG_CNT, v); chk("R7 pulses", v, 4);
        wr(REG_CFG, 24'h11);
        evt_pin_i = 1'b1; wait_n(4); rd(REG_CNT, v); chk("R7 rise ignored", v, 4);
        evt_pin_i = 1'b0; wait_n(4); rd(REG_CNT, v); chk("R7 fall", v, 5);

        // R8 debounce
        wr(REG_CFG, 24'h71);
        for (int w = 1; w <= 3; w++) begin
            evt_pin_i = 1'b1; wait_n(w); evt_pin_i = 1'b0; wait_n(6);
        end
        rd(REG_CNT, v); chk("R8 glitches", v, 5);
        evt_pin_i = 1'b1; wait_n(6); evt_pin_i = 1'b0; wait_n(8);
        rd(REG_CNT, v); chk("R8 long pulse", v, 6);
        wr(REG_CFG, 24'h0);

        // R9 R10 R3 R11 triggers, wake, interrupt gating
        wr(REG_PRESC, 24'h0); wr(REG_STAT, 24'h7); wr(REG_IEN, 24'h0);
        wr(REG_CMP, 24'd4);
        base_a = adc_seen; base_d = dma_seen;
        wr(REG_CFG, 24'h105);
        wait_n(30);
        chk("R10 adc once", adc_seen - base_a, 1);
        chk("R10 dma gated", dma_seen - base_d, 0);
        chk("R3 irq masked", int'(irq_o), 0);
        chk("R9 wake out", int'(wake_o), 1);
        rd(REG_STAT, v); chk("R9 wake flag", (v >> 2) & 1, 1);
        wr(REG_IEN, 24'h1); chk("R3 irq on", int'(irq_o), 1);
        wr(REG_CFG, 24'h284);
        cap_evt_i = 1'b1; @(negedge clk); cap_evt_i = 1'b0;
        wait_n(3);
        rd(REG_STAT, v); chk("R11 cap flag", (v >> 1) & 1, 1);
        chk("R10 dma cap", dma_seen - base_d, 1);
        chk("R10 adc unchanged", adc_seen - base_a, 1);
        wr(REG_CFG, 24'h0);
        wr(REG_STAT, 24'h7);
        rd(REG_STAT, v); chk("R9 R11 cleared", v, 0);
        chk("R9 wake low", int'(wake_o), 0);
        chk("R3 irq low", int'(irq_o), 0);

        finish_run();
    end

endmodule